// File: doc/BRIEF.md
# Downstream Port Host Assignment Controller

This block decides which of two upstream hosts owns each of a set of downstream ports (four by default). Each port has one external assignment pin. The port's owner is reported as a 2-bit code on the output bus, in the port's own slice. The code means host 1, host 2 or unassigned.

A mode input selects how the pins are read. In level mode, the pin level names the host directly. A change is applied only after the pin has held its new level for a programmable delay. In edge mode, each pin acts as a push-button input. A rising pulse is accepted only when it stays high for a fixed minimum number of cycles. After an accepted pulse, the pin must stay low for a programmable time before another pulse can be accepted. Each accepted pulse advances that port's owner one step through a cycle. An enable input decides whether the unassigned state is part of that cycle.

Top module: `port_owner_ctrl`

## Requirements
- R1: Pin n acts only on port n. The owner of port n sits in bits [2n+1:2n] of `owner_o`, and activity on other pins never changes it.
- R2: In level mode, a port whose synchronized pin is low settles to code 2'b00 (host 1). A port whose pin is high settles to code 2'b01 (host 2).
- R3: In level mode, a pin change reaches the output after the two synchronizer cycles plus `dly_val`*TICK_CYC+1 further cycles. It does not reach the output any earlier. A `dly_val` of 0 applies the change three cycles after the pin moves.
- R4: In edge mode, a high pulse shorter than MIN_HIGH_CYC clock cycles leaves the owner unchanged.
- R5: In edge mode, after an accepted pulse, a rising edge is ignored unless the pin has first been low for more than `dly_val`*TICK_CYC cycles. A value of 0 requires no extra low time.
- R6: With `unasg_en` high, each accepted pulse steps the owner from 2'b00 to 2'b01, from 2'b01 to 2'b10 (unassigned), and from 2'b10 back to 2'b00.
- R7: With `unasg_en` low, each accepted pulse toggles the owner between 2'b00 and 2'b01. A port already at 2'b10 steps to 2'b00.
- R8: While reset is asserted, and after it is released, every port's owner is 2'b00.
- R9: A change of `edge_mode` re-arms every edge filter, so the next qualified pulse is accepted even if the low time was cut short. On entering level mode, each owner is reloaded from its pin after the R3 delay.
- R10: The code 2'b11 never appears on any port's slice of `owner_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| asg_pin | input | NP | Asynchronous assignment pins, one per downstream port |
| edge_mode | input | 1 | 0 = level mode, 1 = edge (pulse stepping) mode |
| unasg_en | input | 1 | Adds the unassigned state to the edge-mode cycle |
| dly_val | input | 8 | Programmable delay, in units of TICK_CYC clock cycles |
| owner_o | output | 2*NP | Packed per-port owner codes: 00 host 1, 01 host 2, 10 unassigned |

## Verification
The hardest situation to reach from the ports is a filter that is part-way through its low re-arm wait when the mode flips. In that case only the re-arm on the mode change decides whether the next pulse counts. The stimulus sets up this case on purpose. It accepts a pulse with a long delay value, drops the pin for only a few cycles, and toggles `edge_mode` out and back. It then sends a full pulse, which must advance the owner. The random part sends pulses that are clearly too short or clearly long enough, on random ports, with random `unasg_en`. It also holds random level patterns under random delays, so that both step cycles and the ports' independence are exercised many times.

// File: rtl/port_own_pkg.sv
package port_own_pkg;
  typedef enum logic [1:0] {
    OWN_H1   = 2'b00,
    OWN_H2   = 2'b01,
    OWN_NONE = 2'b10
  } own_e;

  // advance one ownership step on an accepted pulse
  function automatic own_e step_owner(own_e cur, logic allow_none);
    case (cur)
      OWN_H1:  return OWN_H2;
      OWN_H2:  return allow_none ? OWN_NONE : OWN_H1;
      default: return OWN_H1;
    endcase
  endfunction

  // owner selected by a level-mode pin
  function automatic own_e level_owner(logic pin);
    return pin ? OWN_H2 : OWN_H1;
  endfunction

  // number of cycles corresponding to the programmable delay
  function automatic int unsigned hold_cycles(logic [7:0] dly, int unsigned tick);
    return int'(dly) * tick;
  endfunction
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] sr [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) sr[k] <= '0;
    end else begin
      sr[0] <= d_i;
      for (int k = 1; k < STAGES; k++) sr[k] <= sr[k-1];
    end
  end

  assign q_o = sr[STAGES-1];
endmodule

// File: rtl/pulse_qual.sv
module pulse_qual #(
  parameter int CW       = 12,
  parameter int MIN_HIGH = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear_i,
  input  logic          pin_i,
  input  logic [CW-1:0] low_lim_i,
  output logic          accept_o
);
  typedef enum logic [1:0] {ARMED, HI_CHK, WAIT_LO, LO_CHK} qst_e;
  qst_e          st;
  logic [CW-1:0] cnt;
  logic          pin_d;
  logic          rise;

  assign rise     = pin_i & ~pin_d;
  assign accept_o = (st == HI_CHK) && pin_i && (cnt >= CW'(MIN_HIGH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ARMED;
      cnt   <= '0;
      pin_d <= 1'b0;
    end else begin
      pin_d <= pin_i;
      if (clear_i) begin
        st  <= ARMED;
        cnt <= '0;
      end else begin
        case (st)
          ARMED: if (rise) begin
            st  <= HI_CHK;
            cnt <= CW'(1);
          end
          HI_CHK: begin
            if (!pin_i)        st <= ARMED;
            else if (accept_o) st <= WAIT_LO;
            else               cnt <= cnt + 1'b1;
          end
          WAIT_LO: if (!pin_i) begin
            st  <= LO_CHK;
            cnt <= '0;
          end
          default: begin
            if (pin_i)                   st <= WAIT_LO;
            else if (cnt >= low_lim_i)   st <= ARMED;
            else                         cnt <= cnt + 1'b1;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/level_hold.sv
module level_hold #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear_i,
  input  logic          pin_i,
  input  logic [1:0]    owner_i,
  input  logic [CW-1:0] lim_i,
  output logic          load_o
);
  logic [CW-1:0] cnt;
  logic          differ;

  assign differ = owner_i != {1'b0, pin_i};
  assign load_o = differ && !clear_i && (cnt >= lim_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         cnt <= '0;
    else if (clear_i || !differ || load_o) cnt <= '0;
    else                                cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/port_owner_ctrl.sv
module port_owner_ctrl
  import port_own_pkg::*;
#(
  parameter int NP           = 4,
  parameter int SYNC_STAGES  = 2,
  parameter int MIN_HIGH_CYC = 13,
  parameter int TICK_CYC     = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NP-1:0]   asg_pin,
  input  logic            edge_mode,
  input  logic            unasg_en,
  input  logic [7:0]      dly_val,
  output logic [2*NP-1:0] owner_o
);
  localparam int MAX_HOLD = 255 * TICK_CYC;
  localparam int CW       = $clog2(MAX_HOLD + MIN_HIGH_CYC + 2);

  logic [NP-1:0] pin_s;
  logic [NP-1:0] accept_p;
  logic [NP-1:0] load_p;
  logic [NP-1:0] step_ev;
  logic [NP-1:0] load_ev;
  logic          mode_q;
  logic          mode_chg;
  logic [CW-1:0] hold_lim;
  own_e          own_q [NP];

  assign hold_lim = CW'(hold_cycles(dly_val, TICK_CYC));
  assign mode_chg = edge_mode != mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= 1'b0;
    else        mode_q <= edge_mode;
  end

  pin_sync #(.W(NP), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(asg_pin), .q_o(pin_s)
  );

  for (genvar i = 0; i < NP; i++) begin : g_port
    pulse_qual #(.CW(CW), .MIN_HIGH(MIN_HIGH_CYC)) u_qual (
      .clk(clk), .rst_n(rst_n), .clear_i(mode_chg), .pin_i(pin_s[i]),
      .low_lim_i(hold_lim), .accept_o(accept_p[i])
    );

    level_hold #(.CW(CW)) u_hold (
      .clk(clk), .rst_n(rst_n), .clear_i(mode_chg), .pin_i(pin_s[i]),
      .owner_i(own_q[i]), .lim_i(hold_lim), .load_o(load_p[i])
    );

    assign step_ev[i] = edge_mode & accept_p[i];
    assign load_ev[i] = ~edge_mode & load_p[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          own_q[i] <= OWN_H1;
      else if (step_ev[i]) own_q[i] <= step_owner(own_q[i], unasg_en);
      else if (load_ev[i]) own_q[i] <= level_owner(pin_s[i]);
    end

    assign owner_o[2*i +: 2] = own_q[i];
  end
endmodule

// File: rtl/port_owner_chk.sv
module port_owner_chk #(
  parameter int NP = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            unasg_en,
  input logic [NP-1:0]   pin_s,
  input logic [NP-1:0]   accept_p,
  input logic [NP-1:0]   step_ev,
  input logic [NP-1:0]   load_ev,
  input logic [2*NP-1:0] owner_o
);
  for (genvar i = 0; i < NP; i++) begin : g_chk
    p_legal_code_r10: assert property (@(posedge clk) disable iff (!rst_n)
      owner_o[2*i +: 2] != 2'b11);

    p_change_caused_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(owner_o[2*i +: 2]) |-> $past(step_ev[i] | load_ev[i]));

    p_level_target_r2: assert property (@(posedge clk) disable iff (!rst_n)
      load_ev[i] |=> owner_o[2*i +: 2] == {1'b0, $past(pin_s[i])});

    p_three_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (step_ev[i] && unasg_en && owner_o[2*i +: 2] == 2'b01)
      |=> owner_o[2*i +: 2] == 2'b10);

    p_two_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (step_ev[i] && !unasg_en && owner_o[2*i +: 2] == 2'b01)
      |=> owner_o[2*i +: 2] == 2'b00);

    p_accept_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
      accept_p[i] |-> pin_s[i]);
  end
endmodule

bind port_owner_ctrl port_owner_chk #(.NP(NP)) u_chk (
  .clk(clk), .rst_n(rst_n), .unasg_en(unasg_en), .pin_s(pin_s),
  .accept_p(accept_p), .step_ev(step_ev), .load_ev(load_ev), .owner_o(owner_o)
);

// File: tb/sim_port_owner_ctrl.sv
module sim_port_owner_ctrl;
  localparam int NP   = 4;
  localparam int TICK = 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NP-1:0]   pins = '0;
  logic            emode = 1'b0;
  logic            uen = 1'b0;
  logic [7:0]      dly = '0;
  logic [2*NP-1:0] own;

  int checks = 0;
  int fails  = 0;
  logic [1:0] model [NP];

  always #4 clk = ~clk;

  port_owner_ctrl #(.NP(NP), .MIN_HIGH_CYC(13), .TICK_CYC(TICK)) u0 (
    .clk(clk), .rst_n(rst_n), .asg_pin(pins), .edge_mode(emode),
    .unasg_en(uen), .dly_val(dly), .owner_o(own)
  );

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, int p, logic [1:0] exp);
    checks++;
    if (own[2*p +: 2] !== exp) begin
      fails++;
      $display("FAIL %s port%0d actual=%b expected=%b", req, p, own[2*p +: 2], exp);
    end
  endtask

  task automatic chk_all(string req);
    for (int p = 0; p < NP; p++) chk(req, p, model[p]);
  endtask

  function automatic logic [1:0] nxt(logic [1:0] c, logic u);
    if (c == 2'b00) return 2'b01;
    if (c == 2'b01 && u) return 2'b10;
    return 2'b00;
  endfunction

  task automatic pulse(int p, int w, int lo);
    pins[p] = 1'b1;
    tick(w);
    pins[p] = 1'b0;
    tick(lo);
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int p = 0; p < NP; p++) model[p] = 2'b00;
    tick(3);
    chk_all("R8 in reset");
    rst_n = 1'b1;
    tick(3);
    chk_all("R8 after reset");

    // level mode, delay 3*TICK = 24 cycles
    dly = 8'd3;
    pins = 4'b0101;
    tick(20);
    chk_all("R3 not before delay");
    tick(15);
    model[0] = 2'b01; model[1] = 2'b00; model[2] = 2'b01; model[3] = 2'b00;
    chk_all("R2 R1 level result");

    dly = 8'd0;
    pins = 4'b1010;
    tick(2);
    chk_all("R3 zero delay not yet");
    tick(3);
    model[0] = 2'b00; model[1] = 2'b01; model[2] = 2'b00; model[3] = 2'b01;
    chk_all("R3 zero delay applied");

    for (int it = 0; it < 20; it++) begin
      int d;
      d = int'($urandom_range(0, 3));
      dly = 8'(d);
      pins = 4'($urandom_range(0, 15));
      tick(d * TICK + 8);
      for (int p = 0; p < NP; p++) model[p] = {1'b0, pins[p]};
      chk_all("R2 random level");
    end

    // go to edge mode from all host 1
    dly = 8'd0;
    pins = '0;
    tick(6);
    for (int p = 0; p < NP; p++) model[p] = 2'b00;
    emode = 1'b1; uen = 1'b1; dly = 8'd2;
    tick(3);
    for (int s = 0; s < 3; s++) begin
      pulse(0, 20, 30);
      model[0] = nxt(model[0], 1'b1);
      chk_all("R6 three state cycle");
    end

    pulse(1, 8, 30);
    chk_all("R4 short pulse ignored");

    pulse(2, 20, 4);
    model[2] = nxt(model[2], 1'b1);
    pulse(2, 20, 30);
    chk_all("R5 early edge ignored");

    dly = 8'd0;
    pulse(3, 20, 3);
    pulse(3, 20, 30);
    model[3] = nxt(nxt(model[3], 1'b1), 1'b1);
    chk_all("R5 zero low time");

    // two-state cycle
    uen = 1'b0;
    dly = 8'd1;
    pulse(1, 20, 30);
    model[1] = nxt(model[1], 1'b0);
    chk_all("R7 toggle to host 2");
    pulse(1, 20, 30);
    model[1] = nxt(model[1], 1'b0);
    chk_all("R7 toggle back to host 1");
    uen = 1'b1;
    while (model[0] != 2'b10) begin
      pulse(0, 20, 30);
      model[0] = nxt(model[0], 1'b1);
    end
    chk_all("R6 reach unassigned");
    uen = 1'b0;
    pulse(0, 20, 30);
    model[0] = 2'b00;
    chk_all("R7 unassigned to host 1");

    for (int it = 0; it < 30; it++) begin
      int p;
      logic lng;
      p = int'($urandom_range(0, NP - 1));
      lng = 1'($urandom_range(0, 1));
      uen = 1'($urandom_range(0, 1));
      pulse(p, lng ? 20 : 6, 30);
      if (lng) model[p] = nxt(model[p], uen);
      chk_all("R1 R4 R6 R7 random pulses");
    end

    // mode change re-arms a filter caught in its low wait
    dly = 8'd3;
    uen = 1'b1;
    pulse(2, 20, 3);
    model[2] = nxt(model[2], 1'b1);
    emode = 1'b0;
    tick(2);
    emode = 1'b1;
    tick(2);
    pulse(2, 20, 30);
    model[2] = nxt(model[2], 1'b1);
    chk_all("R9 re-armed after mode change");

    // entering level mode reloads from pins
    pins = 4'b0110;
    tick(4);
    emode = 1'b0;
    tick(3 * TICK + 10);
    for (int p = 0; p < NP; p++) model[p] = {1'b0, pins[p]};
    chk_all("R9 level reload");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule